// File: doc/BRIEF.md
# Cross-Domain CPU Event Pulse Generator

This block carries a "CPU event" from the interrupt controller's bus-clock domain into the CPU's free-running clock domain. On the source side, any unmasked line event sets one shared event level register; no per-line status is kept. The level is an asynchronous signal as far as the CPU is concerned. The CPU side passes it through a synchronizer and detects its rising edge. From that edge it emits a single-cycle pulse for the CPU's receive-event input.

In the same cycle as the pulse, the CPU side raises an event-reset signal and sends it back. That signal clears the source level asynchronously, so one assertion of the level gives exactly one pulse. The reset is held until the synchronized level is seen low.

An event can arrive on the source side while the clear is still in progress. Such an event is parked in a deferred flag. It sets the level again once the clear has been released and seen released, so the event is not lost and yields a second pulse.

Top module: `cpu_evt_pulse_gen`

## Requirements
- R1: While either reset is active, and just after reset, the event level, the event pulse and the event reset are all low.
- R2: A high bit on any of the `line_evt` inputs, sampled on a `src_clk` rising edge while no clear is in progress, sets `evt_level` on that edge. Strobes that arrive while the level is already high merge into the same request.
- R3: The level passes through `SYNC_STAGES` CPU-clock flops. The first CPU cycle in which the synchronized level is seen high (it was low the cycle before) produces, one edge later, a `cpu_evt_pulse` exactly one CPU cycle wide.
- R4: `cpu_evt_rst` rises in the same CPU cycle as `cpu_evt_pulse` and never rises without it.
- R5: `cpu_evt_rst` stays high for as long as the synchronized level is high. It falls on the first CPU edge after the synchronized level is seen low.
- R6: While `cpu_evt_rst` is high, `evt_level` is held low, without waiting for a source clock edge.
- R7: A strobe that arrives while a clear is in progress is deferred. A clear is in progress while `cpu_evt_rst` is high or its source-side synchronized copy is high. Once neither is high, the deferred strobe sets the level and yields exactly one further pulse.
- R8: When requests are separated by enough time for the round trip to complete, the number of pulses equals the number of requests. This holds whichever line bit carries each request.
- R9: Several line bits high on the same source edge count as a single request and give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source (bus) clock |
| src_rst_n | input | 1 | Source-domain reset, active low, asynchronous |
| line_evt | input | NUM_LINES | Unmasked line event strobes, synchronous to src_clk |
| cpu_clk | input | 1 | CPU free-running clock |
| cpu_rst_n | input | 1 | CPU-domain reset, active low, asynchronous |
| evt_level | output | 1 | Shared source-side event level, asynchronous to cpu_clk |
| cpu_evt_pulse | output | 1 | One-cycle event pulse for the CPU, synchronous to cpu_clk |
| cpu_evt_rst | output | 1 | Event reset returned to the source, synchronous to cpu_clk |

## Verification
The assertions check on every cycle the following local properties:
- the pulse width;
- that the pulse and the reset start together;
- the hold and release of the reset against the synchronized level;
- that the level is low while the reset is high;
- that a deferred strobe stays parked while a clear is in progress.

Other properties span both clock domains and can only be shown by the bench's scenarios, run with clocks of unrelated frequency:
- that every separated request produces exactly one pulse;
- that merged strobes and same-edge multi-line strobes give a single pulse;
- that a strobe landing inside the clear window gives a second pulse rather than vanishing.

// File: rtl/evt_pulse_pkg.sv
package evt_pulse_pkg;

  // Rising edge of the synchronized level.
  function automatic logic lvl_rise(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // Next state of the returned reset: start on a rise, hold while level seen high.
  function automatic logic rst_next(input logic rise, input logic rst_q, input logic sync_lvl);
    return rise | (rst_q & sync_lvl);
  endfunction

  // Source side: a clear is in progress while the raw reset or its synced copy is high.
  function automatic logic clear_busy(input logic raw_rst, input logic synced_rst);
    return raw_rst | synced_rst;
  endfunction

endpackage

// File: rtl/evt_bit_sync.sv
module evt_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/evt_src_level.sv
module evt_src_level
  import evt_pulse_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_evt,
  input  logic                 clr_async,
  output logic                 level
);
  logic any_evt;
  logic clr_synced;
  logic busy;
  logic deferred;
  logic set_req;

  evt_bit_sync #(.STAGES(SYNC_STAGES)) i_clr_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (clr_async),
    .q    (clr_synced)
  );

  assign any_evt = |line_evt;
  assign busy    = clear_busy(clr_async, clr_synced);
  assign set_req = (any_evt | deferred) & ~busy;

  // Shared event level: asynchronously cleared by the returned reset.
  always_ff @(posedge clk or negedge rst_n or posedge clr_async) begin
    if (!rst_n)         level <= 1'b0;
    else if (clr_async) level <= 1'b0;
    else if (set_req)   level <= 1'b1;
  end

  // Strobes that land while a clear is in progress wait here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  deferred <= 1'b0;
    else if (any_evt && busy)    deferred <= 1'b1;
    else if (!busy)              deferred <= 1'b0;
  end

  a_r6_level_low_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_async |-> !level);

  a_r7_deferred_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (deferred && busy) |=> deferred);

  a_r7_deferred_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (any_evt && busy) |=> deferred);
endmodule

// File: rtl/evt_cpu_edge.sv
module evt_cpu_edge
  import evt_pulse_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_async,
  output logic evt_pulse,
  output logic evt_rst
);
  logic sync_lvl;
  logic sync_lvl_d;
  logic rise;

  evt_bit_sync #(.STAGES(SYNC_STAGES)) i_lvl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (lvl_async),
    .q    (sync_lvl)
  );

  assign rise = lvl_rise(sync_lvl, sync_lvl_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_lvl_d <= 1'b0;
      evt_pulse  <= 1'b0;
      evt_rst    <= 1'b0;
    end else begin
      sync_lvl_d <= sync_lvl;
      evt_pulse  <= rise;
      evt_rst    <= rst_next(rise, evt_rst, sync_lvl);
    end
  end

  a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);

  a_r4_rst_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> evt_rst);

  a_r4_rst_rise_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_rst) |-> evt_pulse);

  a_r5_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rst && sync_lvl) |=> evt_rst);

  a_r5_rst_release: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rst && !sync_lvl) |=> !evt_rst);
endmodule

// File: rtl/cpu_evt_pulse_gen.sv
module cpu_evt_pulse_gen #(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 src_clk,
  input  logic                 src_rst_n,
  input  logic [NUM_LINES-1:0] line_evt,
  input  logic                 cpu_clk,
  input  logic                 cpu_rst_n,
  output logic                 evt_level,
  output logic                 cpu_evt_pulse,
  output logic                 cpu_evt_rst
);
  evt_src_level #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_src (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .line_evt (line_evt),
    .clr_async(cpu_evt_rst),
    .level    (evt_level)
  );

  evt_cpu_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_cpu (
    .clk      (cpu_clk),
    .rst_n    (cpu_rst_n),
    .lvl_async(evt_level),
    .evt_pulse(cpu_evt_pulse),
    .evt_rst  (cpu_evt_rst)
  );

  a_r1_quiet_in_reset: assert property (@(posedge cpu_clk)
    !cpu_rst_n |-> (!cpu_evt_pulse && !cpu_evt_rst));
endmodule

// File: tb/test_cpu_evt_pulse_gen.sv
`timescale 1ns/100ps
module test_cpu_evt_pulse_gen;
  localparam int NL = 16;
  localparam int SS = 2;

  logic          src_clk = 1'b1;
  logic          cpu_clk = 1'b0;
  logic          src_rst_n = 1'b0;
  logic          cpu_rst_n = 1'b0;
  logic [NL-1:0] line_evt = '0;
  logic          evt_level, cpu_evt_pulse, cpu_evt_rst;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  bit done     = 0;

  always #5 cpu_clk = ~cpu_clk;
  always #7 src_clk = ~src_clk;

  cpu_evt_pulse_gen #(.NUM_LINES(NL), .SYNC_STAGES(SS)) i_cpu_evt_pulse_gen (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .line_evt(line_evt),
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .evt_level(evt_level),
    .cpu_evt_pulse(cpu_evt_pulse), .cpu_evt_rst(cpu_evt_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural CPU-side model: history of level samples, expected outputs.
  bit hist[$];
  bit exp_pulse = 0;
  bit exp_rst   = 0;
  always @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      hist = {};
      for (int k = 0; k <= SS; k++) hist.push_back(1'b0);
      exp_pulse = 0;
      exp_rst   = 0;
    end else begin
      bit seen_now, seen_prev, edge_now;
      seen_now  = hist[SS-1];
      seen_prev = hist[SS];
      edge_now  = seen_now && !seen_prev;
      exp_rst   = edge_now || (exp_rst && seen_now);
      exp_pulse = edge_now;
      hist.push_front(evt_level);
      void'(hist.pop_back());
    end
  end

  // Compare on every CPU clock, away from the active edge.
  always @(negedge cpu_clk) begin
    if (cpu_rst_n && !done) begin
      chk("R3 pulse", int'(cpu_evt_pulse), int'(exp_pulse));
      chk("R4/R5 reset", int'(cpu_evt_rst), int'(exp_rst));
      if (cpu_evt_pulse) pulses++;
    end
  end

  task automatic strobe(input logic [NL-1:0] v);
    @(negedge src_clk);
    line_evt = v;
    @(negedge src_clk);
    line_evt = '0;
  endtask

  task automatic settle();
    repeat (20) @(negedge src_clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge cpu_clk);
    // R1: quiet during reset
    chk("R1 level", int'(evt_level), 0);
    chk("R1 pulse", int'(cpu_evt_pulse), 0);
    chk("R1 rst", int'(cpu_evt_rst), 0);
    @(negedge src_clk); src_rst_n = 1'b1;
    @(negedge cpu_clk); cpu_rst_n = 1'b1;
    repeat (4) @(negedge cpu_clk);
    chk("R1 pulse after reset", int'(cpu_evt_pulse), 0);

    // R2: single strobe sets the level at the capturing edge
    pulses = 0;
    @(negedge src_clk); line_evt = 16'h0001;
    @(negedge src_clk); line_evt = '0;
    chk("R2 level set", int'(evt_level), 1);
    settle();
    chk("R8 one pulse", pulses, 1);
    chk("R6 level cleared", int'(evt_level), 0);

    // R9: several lines on the same edge
    pulses = 0;
    strobe(16'hA5C3);
    settle();
    chk("R9 multi-line one pulse", pulses, 1);

    // R2: strobe one source cycle later merges into the same request
    pulses = 0;
    @(negedge src_clk); line_evt = 16'h0010;
    @(negedge src_clk); line_evt = 16'h0200;
    @(negedge src_clk); line_evt = '0;
    settle();
    chk("R2 merged strobes", pulses, 1);

    // R7: strobe while the reset is being returned
    pulses = 0;
    strobe(16'h0004);
    while (!cpu_evt_rst) @(negedge src_clk);
    line_evt = 16'h8000;
    @(negedge src_clk); line_evt = '0;
    chk("R6 level low in clear", int'(evt_level), 0);
    settle();
    chk("R7 deferred second pulse", pulses, 2);
    chk("R7 level idle after", int'(evt_level), 0);

    // R8: many separated requests on rotating lines
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      strobe(NL'(1) << (i % NL));
      repeat (13) @(negedge src_clk);
    end
    settle();
    chk("R8 pulse count", pulses, 20);
    chk("R8 rst idle", int'(cpu_evt_rst), 0);

    finish_run();
  end
endmodule